// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting (8,4) Codec

This block protects a 4-bit payload with an 8-bit codeword. Its encoder places the payload in the positions that are not powers of two. It fills positions 1, 2 and 4 with even-parity check bits and makes position 8 the parity of the other seven bits, so the whole word has even parity.

The decoder takes a received word. It forms a three-bit syndrome that points straight at a faulty position, and it also checks the overall parity. From these two results it chooses one of three outcomes. A clean word passes through as it is. A word with one flipped bit is repaired and then delivered. A word with two flipped bits is withheld, and the decoder asks the sender to transmit it again. Both paths are registered and answer one clock after their input strobe.

Top module: `secdedCodec84`

## Requirements
- R1: Codeword position p (1..8) is carried on vector bit p-1. Payload bit 0 sits at position 3, bit 1 at position 5, bit 2 at position 6 and bit 3 at position 7.
- R2: One cycle after `encValid`, `encCodeValid` is high and `encCode` holds the codeword. Its check bits are position1 = p3^p5^p7, position2 = p3^p6^p7 and position4 = p5^p6^p7, and position 8 makes the parity of all eight bits even. Without `encValid`, `encCodeValid` is low one cycle later.
- R3: A received word with a zero syndrome and even overall parity produces `outValid`, the payload unchanged and `flagNoError`.
- R4: The decoder answers exactly one cycle after `decValid`. In a cycle after `decValid` was low, `outValid`, `retryReq` and all three flags are low.
- R5: A single flipped bit at positions 1..7 gives a nonzero syndrome and odd parity. The decoder inverts the bit the syndrome names, delivers the original payload with `outValid`, and raises `flagCorrected`.
- R6: A flipped bit at position 8 alone gives a zero syndrome and odd parity. The payload is delivered unchanged with `outValid` and `flagCorrected`.
- R7: Two flipped bits give a nonzero syndrome with even parity. The decoder then raises `flagUncorrectable` and `retryReq`, keeps `outValid` low, and leaves `outData` at its previous value.
- R8: At most one of `flagNoError`, `flagCorrected` and `flagUncorrectable` is high in any cycle.
- R9: A synchronous active-high `rst` clears `encCodeValid`, `outValid`, `retryReq` and all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| encValid | input | 1 | Payload present on encData |
| encData | input | 4 | Payload to encode |
| encCodeValid | output | 1 | encCode is valid |
| encCode | output | 8 | Encoded word, position p on bit p-1 |
| decValid | input | 1 | Received word present on decCode |
| decCode | input | 8 | Received word |
| outValid | output | 1 | outData carries a delivered payload |
| outData | output | 4 | Delivered (possibly repaired) payload |
| flagNoError | output | 1 | Word arrived intact |
| flagCorrected | output | 1 | One bit was repaired |
| flagUncorrectable | output | 1 | Double error, payload withheld |
| retryReq | output | 1 | Request to send the word again |

## Verification
The hardest case to reach is the withheld double error, where the delivered data must stay frozen. A broken hold only shows if the payload that went out before differs from the one carried by the damaged word. The bench sweeps every payload and, for each one, delivers the clean word and every single-bit corruption before it applies all 28 two-bit corruptions. Each withheld word therefore follows a successful delivery, and the bench compares `outData` against the payload it recorded from that delivery.

// File: rtl/secdedPkg.sv
package secdedPkg;
  localparam int DATA_W = 4;
  localparam int CODE_W = 8;
  localparam int SYN_W  = 3;

  typedef struct packed {
    logic encLoad;
    logic decLoad;
    logic markClean;
    logic markFixed;
    logic markFail;
  } hamStrobes_t;

  // positions 1,2,4,... carry check bits
  function automatic logic isCheckPos(int p);
    return (p & (p - 1)) == 0;
  endfunction
endpackage

// File: rtl/secdedDatapath.sv
module secdedDatapath
  import secdedPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  hamStrobes_t       strb,
  input  logic [DATA_W-1:0] encData,
  input  logic [CODE_W-1:0] decCode,
  output logic              synNonZero,
  output logic              parityOdd,
  output logic              encCodeValid,
  output logic [CODE_W-1:0] encCode,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              flagNoError,
  output logic              flagCorrected,
  output logic              flagUncorrectable,
  output logic              retryReq
);
  logic [CODE_W-1:0] encWord;
  logic [SYN_W-1:0]  syndrome;
  logic [CODE_W-1:0] fixedWord;
  logic [DATA_W-1:0] fixedData;

  // encoder: scatter payload, then fill check bits and overall parity
  always_comb begin
    int k;
    logic chk;
    encWord = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!isCheckPos(p) && k < DATA_W) begin
        encWord[p-1] = encData[k];
        k++;
      end
    end
    for (int j = 0; j < SYN_W; j++) begin
      chk = 1'b0;
      for (int p = 1; p < CODE_W; p++)
        if (((p >> j) & 1) == 1 && !isCheckPos(p)) chk ^= encWord[p-1];
      encWord[(1 << j) - 1] = chk;
    end
    encWord[CODE_W-1] = ^encWord[CODE_W-2:0];
  end

  // syndrome: one parity check per address bit of the position
  for (genvar j = 0; j < SYN_W; j++) begin : g_syn
    always_comb begin
      syndrome[j] = 1'b0;
      for (int p = 1; p < CODE_W; p++)
        if (((p >> j) & 1) == 1) syndrome[j] ^= decCode[p-1];
    end
  end

  assign synNonZero = |syndrome;
  assign parityOdd  = ^decCode;

  // repair and gather payload
  always_comb begin
    int k;
    fixedWord = decCode;
    if (parityOdd && synNonZero)
      fixedWord[int'(syndrome) - 1] = ~decCode[int'(syndrome) - 1];
    fixedData = '0;
    k = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!isCheckPos(p) && k < DATA_W) begin
        fixedData[k] = fixedWord[p-1];
        k++;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      encCodeValid      <= 1'b0;
      encCode           <= '0;
      outValid          <= 1'b0;
      outData           <= '0;
      flagNoError       <= 1'b0;
      flagCorrected     <= 1'b0;
      flagUncorrectable <= 1'b0;
      retryReq          <= 1'b0;
    end else begin
      encCodeValid <= strb.encLoad;
      if (strb.encLoad) encCode <= encWord;
      outValid <= strb.decLoad;
      if (strb.decLoad) outData <= fixedData;
      flagNoError       <= strb.markClean;
      flagCorrected     <= strb.markFixed;
      flagUncorrectable <= strb.markFail;
      retryReq          <= strb.markFail;
    end
  end
endmodule

// File: rtl/secdedCtrl.sv
module secdedCtrl
  import secdedPkg::*;
(
  input  logic        encValid,
  input  logic        decValid,
  input  logic        synNonZero,
  input  logic        parityOdd,
  output hamStrobes_t strb
);
  always_comb begin
    strb.encLoad   = encValid;
    strb.markClean = decValid && !synNonZero && !parityOdd;
    strb.markFixed = decValid && parityOdd;
    strb.markFail  = decValid && synNonZero && !parityOdd;
    strb.decLoad   = decValid && !strb.markFail;
  end
endmodule

// File: rtl/secdedCodec84.sv
module secdedCodec84
  import secdedPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              encValid,
  input  logic [DATA_W-1:0] encData,
  output logic              encCodeValid,
  output logic [CODE_W-1:0] encCode,
  input  logic              decValid,
  input  logic [CODE_W-1:0] decCode,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              flagNoError,
  output logic              flagCorrected,
  output logic              flagUncorrectable,
  output logic              retryReq
);
  hamStrobes_t strb;
  logic synNonZero;
  logic parityOdd;

  secdedCtrl i_ctrl (
    .encValid  (encValid),
    .decValid  (decValid),
    .synNonZero(synNonZero),
    .parityOdd (parityOdd),
    .strb      (strb)
  );

  secdedDatapath i_dp (
    .clk              (clk),
    .rst              (rst),
    .strb             (strb),
    .encData          (encData),
    .decCode          (decCode),
    .synNonZero       (synNonZero),
    .parityOdd        (parityOdd),
    .encCodeValid     (encCodeValid),
    .encCode          (encCode),
    .outValid         (outValid),
    .outData          (outData),
    .flagNoError      (flagNoError),
    .flagCorrected    (flagCorrected),
    .flagUncorrectable(flagUncorrectable),
    .retryReq         (retryReq)
  );
endmodule

// File: rtl/secdedChecker.sv
module secdedChecker
  import secdedPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              encValid,
  input logic [DATA_W-1:0] encData,
  input logic              encCodeValid,
  input logic [CODE_W-1:0] encCode,
  input logic              decValid,
  input logic [CODE_W-1:0] decCode,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              flagNoError,
  input logic              flagCorrected,
  input logic              flagUncorrectable,
  input logic              retryReq
);
  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (rst) encValid |=> encCodeValid); // R2
  AST_ENC_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst) encCodeValid |-> (^encCode) == 1'b0); // R2
  AST_DEC_ANSWERS: assert property (@(posedge clk) disable iff (rst) decValid |=> (outValid || retryReq)); // R4
  AST_DEC_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !decValid |=> !outValid && !retryReq && !flagNoError && !flagCorrected && !flagUncorrectable); // R4
  AST_RETRY_BLOCKS_VALID: assert property (@(posedge clk) disable iff (rst) retryReq |-> !outValid); // R7
  AST_RETRY_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst) retryReq |-> $stable(outData)); // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0({flagNoError, flagCorrected, flagUncorrectable})); // R8
endmodule

bind secdedCodec84 secdedChecker i_chk (.*);

// File: tb/test_secdedCodec84.sv
module test_secdedCodec84;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst;
  logic       encValid;
  logic [3:0] encData;
  logic       encCodeValid;
  logic [7:0] encCode;
  logic       decValid;
  logic [7:0] decCode;
  logic       outValid;
  logic [3:0] outData;
  logic       flagNoError, flagCorrected, flagUncorrectable, retryReq;

  int nVec = 0;
  int nFail = 0;
  logic [3:0] lastData;

  always #(CLK_PERIOD/2) clk = ~clk;

  secdedCodec84 i_secdedCodec84 (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] refEncode(logic [3:0] d);
    logic a1, a2, a4, a8;
    logic [7:0] w;
    a1 = d[0] ^ d[1] ^ d[3];
    a2 = d[0] ^ d[2] ^ d[3];
    a4 = d[1] ^ d[2] ^ d[3];
    w = {1'b0, d[3], d[2], d[1], a4, d[0], a2, a1};
    a8 = ^w[6:0];
    w[7] = a8;
    return w;
  endfunction

  // status packed as {outValid, noErr, corr, uncorr, retry}
  function automatic logic [7:0] st();
    return {3'b0, outValid, flagNoError, flagCorrected, flagUncorrectable, retryReq};
  endfunction

  task automatic decodeOne(logic [7:0] w);
    @(negedge clk);
    decCode = w; decValid = 1'b1;
    @(negedge clk);
    decValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nVec++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    rst = 1'b1; encValid = 1'b0; encData = '0; decValid = 1'b0; decCode = '0;
    repeat (3) @(negedge clk);
    check("R9 reset status", st(), 8'h00);
    check("R9 reset encValid", {7'b0, encCodeValid}, 8'h00);
    rst = 1'b0;

    for (int d = 0; d < 16; d++) begin
      logic [7:0] cw;
      cw = refEncode(d[3:0]);
      // encoder R1 R2
      @(negedge clk);
      encData = d[3:0]; encValid = 1'b1;
      @(negedge clk);
      encValid = 1'b0;
      check("R1 R2 encode word", encCode, cw);
      check("R2 encode valid", {7'b0, encCodeValid}, 8'h01);
      @(negedge clk);
      check("R2 encode valid drops", {7'b0, encCodeValid}, 8'h00);

      // clean word R3
      decodeOne(cw);
      check("R3 clean status", st(), 8'h18);
      check("R3 clean data", {4'b0, outData}, {4'b0, d[3:0]});
      lastData = d[3:0];
      @(negedge clk);
      check("R4 idle after answer", st(), 8'h00);

      // single errors R5 R6
      for (int p = 0; p < 8; p++) begin
        decodeOne(cw ^ (8'h01 << p));
        check(p == 7 ? "R6 parity-bit status" : "R5 single status", st(), 8'h14);
        check(p == 7 ? "R6 parity-bit data" : "R5 single data", {4'b0, outData}, {4'b0, d[3:0]});
        lastData = d[3:0];
      end

      // double errors R7 R8
      for (int a = 0; a < 8; a++) begin
        for (int b = a + 1; b < 8; b++) begin
          decodeOne(cw ^ (8'h01 << a) ^ (8'h01 << b));
          check("R7 R8 double status", st(), 8'h03);
          check("R7 double data held", {4'b0, outData}, {4'b0, lastData});
        end
      end
      @(negedge clk);
      check("R4 idle quiet", st(), 8'h00);
    end

    // reset while an answer is pending R9
    @(negedge clk);
    decCode = refEncode(4'h5); decValid = 1'b1; encValid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    decValid = 1'b0; encValid = 1'b0;
    check("R9 reset clears status", st(), 8'h00);
    check("R9 reset clears enc valid", {7'b0, encCodeValid}, 8'h00);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule